// File: doc/BRIEF.md
# Conservative Conditional-Swap One-to-Four Demultiplexer

The block steers a single data bit to one of four result lines. Two address bits choose the line. The block is built only from conditional-swap cells. Each cell passes its control bit through unchanged. When the control bit is 1, the cell's two data bits go straight through. When the control bit is 0, the two data bits trade places. Because a cell only moves bits, it never creates or destroys a 1. The count of ones leaving the block always equals the count entering it, constant lines included.

Three constant (ancilla) inputs feed the empty data slots of the cells. In normal use they are held at 0, so the lines that are not selected read 0. The two address bits leave the block unchanged on two sink outputs. This gives six input lines and six output lines.

Each cell column is followed by a register that stands for a one-step wire. Every line, including the address, constant and valid lines, crosses exactly two registers. So all results appear together, two clock cycles after their inputs. A valid flag travels alongside the data with the same two-cycle delay.

Top module: `fredkin_demux4`

## Requirements
- R1: While `rst_n` is low, `y_o`, `sink_a0_o`, `sink_a1_o` and `out_vld` are all 0.
- R2: With `anc_i` = 0, `y_o[k]` equals `x_i` for k = 2*`a1_i` + `a0_i`, and every other bit of `y_o` is 0.
- R3: Every output reflects the inputs sampled exactly two rising clock edges earlier, with the same delay on every line.
- R4: `sink_a0_o` and `sink_a1_o` reproduce `a0_i` and `a1_i` from two cycles earlier.
- R5: The number of ones on {`y_o`, `sink_a0_o`, `sink_a1_o`} equals the number of ones on {`x_i`, `a0_i`, `a1_i`, `anc_i`} from two cycles earlier, for any ancilla values.
- R6: `out_vld` equals `in_vld` from two cycles earlier, independent of the data lines.
- R7: With `anc_i` = 0, at most one bit of `y_o` is 1.
- R8: Each cell keeps its data order when its control is 1 and exchanges its data when its control is 0. The cells are wired as follows, where ":" separates the value for control 1 from the value for control 0:
  - First column, control `a1_i`, data (`x_i`, `anc_i[0]`): it yields p = `a1_i` ? `x_i` : `anc_i[0]` and q = `a1_i` ? `anc_i[0]` : `x_i`.
  - Second column, two cells, both with control `a0_i` carried through.
  - The first of these gives `y_o[3]` = `a0_i` ? p : `anc_i[1]` and `y_o[2]` = `a0_i` ? `anc_i[1]` : p.
  - The second gives `y_o[1]` = `a0_i` ? q : `anc_i[2]` and `y_o[0]` = `a0_i` ? `anc_i[2]` : q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Marks the input lines as carrying a vector |
| x_i | input | 1 | Data bit to route |
| a0_i | input | 1 | Address bit, weight 1 |
| a1_i | input | 1 | Address bit, weight 2 |
| anc_i | input | 3 | Constant lines for the empty cell slots, normally 0 |
| out_vld | output | 1 | Valid flag, delayed two cycles |
| y_o | output | 4 | Result lines, one per address value |
| sink_a0_o | output | 1 | Address bit 0 returned as garbage |
| sink_a1_o | output | 1 | Address bit 1 returned as garbage |

## Verification
The bench streams all 64 settings of data, address and ancilla bits back to back, one per cycle, so each result must come out of the correct pipeline slot.

The first eight settings have zero ancillas. They cover the full demultiplexer truth table and separate a wrong address decode from a wrong swap sense. The remaining 56 settings put 1s on the constant lines. That exposes a swapped cell pairing or a lost bit, which the ones-count comparison and the per-line cell model both catch.

The valid flag follows its own pattern, uncorrelated with the data, so a flag tied to the data path would be noticed.

// File: rtl/fredkin_demux4.sv
module fredkin_demux4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic       x_i,
  input  logic       a0_i,
  input  logic       a1_i,
  input  logic [2:0] anc_i,
  output logic       out_vld,
  output logic [3:0] y_o,
  output logic       sink_a0_o,
  output logic       sink_a1_o
);

  // column 1: one cell, control a1_i
  logic c1_p, c1_q;
  assign c1_p = a1_i ? x_i      : anc_i[0];
  assign c1_q = a1_i ? anc_i[0] : x_i;

  // unit-wire registers after column 1
  logic w_a1, w_a0, w_p, w_q, w_b2, w_b3, w_v;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_a1 <= 1'b0; w_a0 <= 1'b0; w_p <= 1'b0; w_q <= 1'b0;
      w_b2 <= 1'b0; w_b3 <= 1'b0; w_v <= 1'b0;
    end else begin
      w_a1 <= a1_i; w_a0 <= a0_i; w_p <= c1_p; w_q <= c1_q;
      w_b2 <= anc_i[1]; w_b3 <= anc_i[2]; w_v <= in_vld;
    end
  end

  // column 2: two cells sharing a0 by pass-through
  logic c2_mid;
  logic [3:0] c2_y;
  assign c2_y[3] = w_a0 ? w_p  : w_b2;
  assign c2_y[2] = w_a0 ? w_b2 : w_p;
  assign c2_mid  = w_a0;
  assign c2_y[1] = c2_mid ? w_q  : w_b3;
  assign c2_y[0] = c2_mid ? w_b3 : w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_o <= 4'b0; sink_a0_o <= 1'b0; sink_a1_o <= 1'b0; out_vld <= 1'b0;
    end else begin
      y_o <= c2_y; sink_a0_o <= c2_mid; sink_a1_o <= w_a1; out_vld <= w_v;
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (y_o == 4'b0 && !out_vld && !sink_a0_o && !sink_a1_o));

  // R5
  ones_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd2 |-> $countones({y_o, sink_a0_o, sink_a1_o}) ==
                     $countones($past({x_i, a0_i, a1_i, anc_i}, 2)));

  // R5
  ones_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm != 2'd0 |-> $countones({w_a1, w_a0, w_p, w_q, w_b2, w_b3}) ==
                     $countones($past({x_i, a0_i, a1_i, anc_i})));

  // R4
  sink_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd2 |-> {sink_a1_o, sink_a0_o} == $past({a1_i, a0_i}, 2));

  // R6
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd2 |-> out_vld == $past(in_vld, 2));

  // R7
  one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && $past(anc_i, 2) == 3'b0) |-> $onehot0(y_o));

  // R2
  route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && $past(anc_i, 2) == 3'b0) |->
      y_o == ({3'b0, $past(x_i, 2)} << {$past(a1_i, 2), $past(a0_i, 2)}));

endmodule

// File: tb/fredkin_demux4_test.sv
module fredkin_demux4_test;
  logic clk = 1'b0;
  logic rst_n, in_vld, x_i, a0_i, a1_i;
  logic [2:0] anc_i;
  logic out_vld, sink_a0_o, sink_a1_o;
  logic [3:0] y_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fredkin_demux4 uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_i(x_i), .a0_i(a0_i),
    .a1_i(a1_i), .anc_i(anc_i), .out_vld(out_vld), .y_o(y_o),
    .sink_a0_o(sink_a0_o), .sink_a1_o(sink_a1_o)
  );

  function automatic logic [3:0] model_y(input logic [5:0] v);
    logic x, a0, a1, p, q;
    logic [2:0] b;
    logic [3:0] y;
    x = v[0]; a0 = v[1]; a1 = v[2]; b = v[5:3];
    p = a1 ? x : b[0];
    q = a1 ? b[0] : x;
    y[3] = a0 ? p : b[1];
    y[2] = a0 ? b[1] : p;
    y[1] = a0 ? q : b[2];
    y[0] = a0 ? b[2] : q;
    return y;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  logic [5:0] hist [0:63];
  logic       hvld [0:63];

  initial begin
    rst_n = 1'b0; in_vld = 1'b1; x_i = 1'b1; a0_i = 1'b1; a1_i = 1'b1;
    anc_i = 3'b111;
    repeat (3) @(negedge clk);
    check("R1 y", int'(y_o), 0);
    check("R1 vld", int'(out_vld), 0);
    check("R1 sink", int'({sink_a1_o, sink_a0_o}), 0);
    rst_n = 1'b1; in_vld = 1'b0; x_i = 1'b0; a0_i = 1'b0; a1_i = 1'b0;
    anc_i = 3'b0;
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        logic [5:0] v;
        int idx;
        v = hist[i-2];
        idx = 2 * v[2] + v[1];
        check("R6 valid", int'(out_vld), int'(hvld[i-2]));
        check("R4 sink", int'({sink_a1_o, sink_a0_o}), int'(v[2:1]));
        check("R5 ones", $countones({y_o, sink_a0_o, sink_a1_o}), $countones(v));
        if (v[5:3] == 3'b0) begin
          check("R2 R3 route", int'(y_o), int'(v[0]) << idx);
          check("R7 onehot", int'($onehot0(y_o)), 1);
        end else begin
          check("R8 cells", int'(y_o), int'(model_y(v)));
        end
      end
      if (i < 64) begin
        logic [5:0] nv;
        nv = i[5:0];
        hist[i] = nv;
        hvld[i] = i[1] ^ i[4] ^ i[0];
        {anc_i, a1_i, a0_i, x_i} = nv;
        in_vld = hvld[i];
      end else begin
        {anc_i, a1_i, a0_i, x_i} = 6'b0;
        in_vld = 1'b0;
      end
    end
    // R3: a single pulse must not show one cycle later, only two
    x_i = 1'b1; a0_i = 1'b1; a1_i = 1'b1; in_vld = 1'b1;
    @(negedge clk);
    x_i = 1'b0; a0_i = 1'b0; a1_i = 1'b0; in_vld = 1'b0;
    check("R3 early", int'(y_o), 0);
    @(negedge clk);
    check("R3 on time", int'(y_o), 8);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule